// File: doc/BRIEF.md
# SPI Slave Shift Engine

This block is the serial half of an SPI slave. An external master drives the clock, chip-select and data-in lines. The block drives the data-out line and an enable for it. All three incoming lines are brought into the system clock domain through two-flop synchronizers. Clock edges are then found by comparing successive synchronized samples, so the serial clock has to run at no more than a quarter of the system clock rate.

Four static configuration inputs set the mode:
- clock idle polarity,
- clock phase,
- bit order,
- transfer length of 8 or 16 bits.

The host places a word on `tx_word`. Each completed transfer presents the received word on `rx_word` together with a single-cycle `rx_done` strobe.

What is shifted out depends on how the chip-select line behaves between transfers. If chip-select was released before the transfer, the block sends the contents of `tx_word`. If chip-select stays active from one transfer into the next, the block sends back the word it received in the previous transfer.

Top module: `spi_slave_core`

## Requirements
- R1: While `rst_n` is low and after its release, `rx_done` is 0, `rx_word` is 0 and `spi_miso_oe` is 0.
- R2: Whenever chip-select (`spi_ss_n`, active low) is high, `spi_miso_oe` is 0 and `spi_miso` is 0. While it is held low, `spi_miso_oe` is 1 from the third system clock onwards.
- R3: A transfer that begins with a high-to-low transition of `spi_ss_n` shifts out the value `tx_word` had when that transition was synchronized.
- R4: When `spi_ss_n` stays low after a transfer completes, the next transfer shifts out the word received in the completed transfer instead of `tx_word`.
- R5: With `cfg_wide`=0 a transfer is 8 bits long. Only `tx_word[7:0]` is sent, and `rx_word[15:8]` reads 0. With `cfg_wide`=1 a transfer is 16 bits long and uses the whole word.
- R6: With `cfg_lsb_first`=0 the most significant bit of the active width is sent and received first. With `cfg_lsb_first`=1 bit 0 comes first.
- R7: The data line is sampled on rising SCK edges when `cfg_cpol` equals `cfg_cpha`, and on falling edges otherwise. With `cfg_cpha`=0 the first bit is on `spi_miso` before the first SCK edge. With `cfg_cpha`=1 the first bit is on `spi_miso` by the second SCK edge. `cfg_cpol` gives the SCK idle level.
- R8: After the last sampling edge of a transfer, `rx_done` is high for exactly one system clock, and `rx_word` carries the received word in that same cycle. `rx_word` changes in no other cycle.
- R9: SCK edges seen while `spi_ss_n` is high have no effect. Releasing `spi_ss_n` before a transfer completes abandons it without an `rx_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing edge |
| cfg_lsb_first | input | 1 | 1 sends and receives bit 0 first |
| cfg_wide | input | 1 | 0 for 8-bit, 1 for 16-bit transfers |
| tx_word | input | 16 | Word sent after a chip-select release |
| spi_sck | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when not enabled |
| spi_miso_oe | output | 1 | Output enable for the data-out pad |
| rx_word | output | 16 | Last received word |
| rx_done | output | 1 | One-cycle strobe marking a completed transfer |

## Verification
The bound checker watches several properties on every cycle:
- the data-out enable and the level it drives while chip-select is high;
- that the done strobe lasts a single cycle;
- that the received word changes only together with the strobe;
- that an 8-bit word has a clear upper byte;
- that a strobe never appears unless chip-select was active.

Other behaviours can only be shown by the bench's transfers. These are the bit order, the choice of sampling edge for each polarity and phase pair, the echo of the previous word when chip-select is held, the return to `tx_word` after a release, and the silent loss of an abandoned transfer.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  localparam int unsigned SPI_WORD_W   = 16;
  localparam int unsigned SPI_NARROW_W = 8;
  localparam int unsigned SYNC_STAGES  = 2;

  // bit positions of the synchronized pin bundle
  localparam int unsigned PIN_SCK  = 0;
  localparam int unsigned PIN_SS   = 1;
  localparam int unsigned PIN_MOSI = 2;
  localparam int unsigned PIN_CNT  = 3;

  typedef struct packed {
    logic samp;
    logic shft;
    logic ss_act;
    logic ss_start;
  } spi_evt_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned LINES  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [LINES-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout,
  output logic [LINES-1:0] dlast
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [DEPTH-1:0] pipe_q;
    logic [DEPTH-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[DEPTH-2:0], din[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= {DEPTH{RST_VAL[g]}};
      end else begin
        pipe_q <= pipe_d;
      end
    end

    assign dout[g]  = pipe_q[STAGES-1];
    assign dlast[g] = pipe_q[STAGES];
  end
endmodule

// File: rtl/spi_edge_dec.sv
module spi_edge_dec
  import spi_slave_pkg::*;
(
  input  logic     cfg_cpol,
  input  logic     cfg_cpha,
  input  logic     sck_now,
  input  logic     sck_last,
  input  logic     ss_now_n,
  input  logic     ss_last_n,
  output spi_evt_t evt
);
  logic rise;
  logic fall;
  logic samp_on_rise;

  always_comb begin
    rise         = sck_now & ~sck_last;
    fall         = ~sck_now & sck_last;
    samp_on_rise = (cfg_cpol == cfg_cpha);
    evt.ss_act   = ~ss_now_n;
    evt.ss_start = ~ss_now_n & ss_last_n;
    evt.samp     = evt.ss_act & (samp_on_rise ? rise : fall);
    evt.shft     = evt.ss_act & (samp_on_rise ? fall : rise);
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_slave_pkg::*;
#(
  parameter int unsigned DATA_W   = SPI_WORD_W,
  parameter int unsigned NARROW_W = SPI_NARROW_W,
  localparam int unsigned CNT_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lsb_first,
  input  logic              cfg_wide,
  input  logic [DATA_W-1:0] tx_word,
  input  spi_evt_t          evt,
  input  logic              mosi_bit,
  output logic              miso_bit,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_done
);
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic [CNT_W-1:0]  last_idx;
  logic [DATA_W-1:0] width_mask;
  logic [DATA_W-1:0] rx_msb;
  logic [DATA_W-1:0] rx_lsb;
  logic [DATA_W-1:0] rx_ins;
  logic [DATA_W-1:0] rx_final;

  always_comb begin
    last_idx   = cfg_wide ? CNT_W'(DATA_W - 1) : CNT_W'(NARROW_W - 1);
    width_mask = cfg_wide ? {DATA_W{1'b1}}
                          : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    rx_msb     = {rx_q[DATA_W-2:0], mosi_bit};
    rx_lsb     = rx_q >> 1;
    rx_lsb[last_idx] = mosi_bit;
    rx_ins     = cfg_lsb_first ? rx_lsb : rx_msb;
    rx_final   = rx_ins & width_mask;
  end

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    word_d = word_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (evt.ss_start) begin
      tx_d  = tx_word & width_mask;
      rx_d  = '0;
      cnt_d = '0;
    end else if (!evt.ss_act) begin
      cnt_d = '0;
    end else if (evt.samp) begin
      rx_d = rx_ins;
      if (cnt_q == last_idx) begin
        done_d = 1'b1;
        word_d = rx_final;
        tx_d   = rx_final;   // echoed if select stays active
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (evt.shft && (cnt_q != '0)) begin
      tx_d = cfg_lsb_first ? (tx_q >> 1) : (tx_q << 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      word_q <= '0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      word_q <= word_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    if (cfg_lsb_first) begin
      miso_bit = tx_q[0];
    end else begin
      miso_bit = cfg_wide ? tx_q[DATA_W-1] : tx_q[NARROW_W-1];
    end
  end

  assign rx_word = word_q;
  assign rx_done = done_q;
endmodule

// File: rtl/spi_slave_core.sv
module spi_slave_core
  import spi_slave_pkg::*;
#(
  parameter int unsigned DATA_W   = SPI_WORD_W,
  parameter int unsigned NARROW_W = SPI_NARROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              cfg_wide,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              spi_sck,
  input  logic              spi_ss_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_done
);
  localparam logic [PIN_CNT-1:0] PIN_RST = PIN_CNT'(1) << PIN_SS;

  logic [PIN_CNT-1:0] pins_raw;
  logic [PIN_CNT-1:0] pins_now;
  logic [PIN_CNT-1:0] pins_last;
  spi_evt_t           evt;
  logic               miso_bit;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SCK]  = spi_sck;
    pins_raw[PIN_SS]   = spi_ss_n;
    pins_raw[PIN_MOSI] = spi_mosi;
  end

  spi_pin_sync #(
    .LINES   (PIN_CNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pins_raw),
    .dout  (pins_now),
    .dlast (pins_last)
  );

  spi_edge_dec u_edge (
    .cfg_cpol  (cfg_cpol),
    .cfg_cpha  (cfg_cpha),
    .sck_now   (pins_now[PIN_SCK]),
    .sck_last  (pins_last[PIN_SCK]),
    .ss_now_n  (pins_now[PIN_SS]),
    .ss_last_n (pins_last[PIN_SS]),
    .evt       (evt)
  );

  spi_shift_core #(
    .DATA_W   (DATA_W),
    .NARROW_W (NARROW_W)
  ) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_lsb_first (cfg_lsb_first),
    .cfg_wide      (cfg_wide),
    .tx_word       (tx_word),
    .evt           (evt),
    .mosi_bit      (pins_now[PIN_MOSI]),
    .miso_bit      (miso_bit),
    .rx_word       (rx_word),
    .rx_done       (rx_done)
  );

  assign spi_miso_oe = evt.ss_act;
  assign spi_miso    = evt.ss_act & miso_bit;
endmodule

// File: rtl/spi_slave_chk.sv
module spi_slave_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wide,
  input logic              spi_ss_n,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic [DATA_W-1:0] rx_word,
  input logic              rx_done
);
  // R2: a select held high for three cycles leaves the pad disabled
  p_oe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_ss_n && $past(spi_ss_n) && $past(spi_ss_n, 2)) |-> !spi_miso_oe);

  // R2: a disabled pad carries a low level
  p_miso_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_miso_oe |-> !spi_miso);

  // R8: the strobe lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R8: the received word only moves together with the strobe
  p_word_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> rx_done);

  // R5: an 8-bit word has a clear upper part
  p_narrow_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !cfg_wide) |-> (rx_word[DATA_W-1:NARROW_W] == '0));

  // R9: no completion unless the select was active the cycle before
  p_done_needs_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(spi_miso_oe));
endmodule

bind spi_slave_core spi_slave_chk #(
  .DATA_W   (DATA_W),
  .NARROW_W (NARROW_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wide    (cfg_wide),
  .spi_ss_n    (spi_ss_n),
  .spi_miso    (spi_miso),
  .spi_miso_oe (spi_miso_oe),
  .rx_word     (rx_word),
  .rx_done     (rx_done)
);

// File: tb/tb_spi_slave_core.sv
module tb_spi_slave_core;
  localparam int HALF = 8;
  localparam int NVEC = 9;
  // {cpol,cpha,lsb_first,wide, mosi word, tx word}
  localparam logic [35:0] VEC [NVEC] = '{
    36'h0_00A5_003C,
    36'h4_0081_00F0,
    36'h8_0042_0099,
    36'hC_00FF_0001,
    36'h2_0012_00C8,
    36'hF_BEEF_1234,
    36'h5_8001_7FFE,
    36'hB_5A5A_C3C3,
    36'h0_0055_AB66
  };

  logic        clk;
  logic        rst_n;
  logic        cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_wide;
  logic [15:0] tx_word;
  logic        spi_sck, spi_ss_n, spi_mosi;
  logic        spi_miso, spi_miso_oe;
  logic [15:0] rx_word;
  logic        rx_done;

  int n_cmp = 0;
  int n_bad = 0;
  int done_cnt = 0;
  int dbl_cnt = 0;
  int stray_cnt = 0;
  int cyc = 0;
  logic [15:0] done_word = '0;
  logic        prev_done = 1'b0;
  logic [15:0] prev_word = '0;

  spi_slave_core dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_wide(cfg_wide),
    .tx_word(tx_word),
    .spi_sck(spi_sck), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .rx_word(rx_word), .rx_done(rx_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_done) begin
        done_cnt  = done_cnt + 1;
        done_word = rx_word;
        if (prev_done) dbl_cnt = dbl_cnt + 1;
      end else if (rx_word !== prev_word) begin
        stray_cnt = stray_cnt + 1;
      end
    end
    prev_done = rx_done;
    prev_word = rx_word;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_cmp = n_cmp + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [3:0] c);
    spi_ss_n = 1'b1;
    {cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_wide} = c;
    spi_sck = cfg_cpol;
    tick(2 * HALF);
  endtask

  task automatic xfer(input logic [15:0] mo, input bit rel, output logic [15:0] mi);
    int n;
    n  = cfg_wide ? 16 : 8;
    mi = '0;
    if (spi_ss_n) begin
      spi_sck = cfg_cpol;
      tick(HALF);
      spi_ss_n = 1'b0;
      tick(2 * HALF);
    end
    for (int i = 0; i < n; i++) begin
      int p;
      p = cfg_lsb_first ? i : n - 1 - i;
      if (!cfg_cpha) begin
        spi_mosi = mo[p];
        tick(HALF);
        mi[p] = spi_miso;
        spi_sck = ~spi_sck;
        tick(HALF);
        spi_sck = ~spi_sck;
      end else begin
        spi_sck = ~spi_sck;
        spi_mosi = mo[p];
        tick(HALF);
        mi[p] = spi_miso;
        spi_sck = ~spi_sck;
        tick(HALF);
      end
    end
    tick(HALF);
    if (rel) begin
      spi_ss_n = 1'b1;
      tick(2 * HALF);
    end
  endtask

  task automatic run(input string req, input logic [15:0] mo, input bit rel,
                     input logic [15:0] exp_mi, input logic [15:0] exp_rx);
    logic [15:0] mi;
    int d0;
    d0 = done_cnt;
    xfer(mo, rel, mi);
    chk({req, " miso word"}, mi, exp_mi);
    chk({req, " done pulses R8"}, 16'(done_cnt - d0), 16'd1);
    chk({req, " rx word"}, done_word, exp_rx);
  endtask

  initial begin
    rst_n = 1'b0;
    {cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_wide} = 4'h0;
    tx_word = '0;
    spi_sck = 1'b0;
    spi_ss_n = 1'b1;
    spi_mosi = 1'b0;
    tick(4);
    // R1 reset state
    chk("R1 rx_done in reset", {15'd0, rx_done}, 16'd0);
    chk("R1 rx_word in reset", rx_word, 16'h0000);
    chk("R1 oe in reset", {15'd0, spi_miso_oe}, 16'd0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 rx_word after reset", rx_word, 16'h0000);
    chk("R1 oe after reset", {15'd0, spi_miso_oe}, 16'd0);

    // table walk: R3 R5 R6 R7 across every mode pair
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] msk;
      set_cfg(VEC[v][35:32]);
      tx_word = VEC[v][15:0];
      msk = cfg_wide ? 16'hFFFF : 16'h00FF;
      run($sformatf("R3 R5 R6 R7 vec%0d", v), VEC[v][31:16], 1'b1,
          VEC[v][15:0] & msk, VEC[v][31:16] & msk);
    end

    // R4: select held between transfers echoes the previous word
    set_cfg(4'h0);
    tx_word = 16'h00C3;
    run("R4 first held", 16'h00A5, 1'b0, 16'h00C3, 16'h00A5);
    chk("R2 oe while held", {15'd0, spi_miso_oe}, 16'd1);
    run("R4 second held", 16'h003C, 1'b0, 16'h00A5, 16'h003C);
    run("R4 third then release", 16'h0011, 1'b1, 16'h003C, 16'h0011);
    chk("R2 oe after release", {15'd0, spi_miso_oe}, 16'd0);
    run("R3 after release", 16'h0022, 1'b1, 16'h00C3, 16'h0022);

    // R4 in 16-bit, lsb-first, cpha=1, cpol=1
    set_cfg(4'hF);
    tx_word = 16'h0F0F;
    run("R4 wide first", 16'h1357, 1'b0, 16'h0F0F, 16'h1357);
    run("R4 wide echo", 16'hFACE, 1'b1, 16'h1357, 16'hFACE);

    // R9: SCK activity while deselected is ignored
    set_cfg(4'h0);
    tx_word = 16'h0096;
    begin
      int d0;
      d0 = done_cnt;
      for (int k = 0; k < 20; k++) begin
        spi_mosi = k[0];
        spi_sck = ~spi_sck;
        tick(HALF);
      end
      spi_sck = 1'b0;
      tick(2 * HALF);
      chk("R9 no done while deselected", 16'(done_cnt - d0), 16'd0);
      chk("R2 oe low while deselected", {15'd0, spi_miso_oe}, 16'd0);
      run("R9 transfer after idle clocks", 16'h0069, 1'b1, 16'h0096, 16'h0069);

      // R9: aborted transfer gives no done and next transfer sends tx_word
      d0 = done_cnt;
      spi_ss_n = 1'b0;
      tick(2 * HALF);
      for (int k = 0; k < 5; k++) begin
        spi_mosi = 1'b1;
        tick(HALF);
        spi_sck = 1'b1;
        tick(HALF);
        spi_sck = 1'b0;
      end
      tick(HALF);
      spi_ss_n = 1'b1;
      tick(2 * HALF);
      chk("R9 no done on abort", 16'(done_cnt - d0), 16'd0);
      chk("R9 rx_word kept after abort", rx_word, 16'h0069);
      run("R9 R3 after abort", 16'h00E1, 1'b1, 16'h0096, 16'h00E1);
    end

    chk("R8 strobe never two cycles", 16'(dbl_cnt), 16'd0);
    chk("R8 rx_word moves only with strobe", 16'(stray_cnt), 16'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule